// File: doc/BRIEF.md
# Serial Debug Port for Word Memory Access

This block is a serial-bus slave that lets an external master read and write a 16-bit-addressed, 16-bit-wide memory space inside the chip. The master selects the slave with an active-low select line, shifts an 8-bit command and a 16-bit address in MSB first, and then either shifts write data in or clocks read data out. The serial pins are brought into the system clock domain through a synchronizer. All protocol decoding runs on the system clock, and the memory side is a plain synchronous port.

A read returns a 16-bit confirmation word before the data. This word is the command byte followed by the high byte of the address, so the master can tell that the slave decoded its request. The select line may stay low after the first word. Both reads and writes then continue through consecutive addresses without the address being sent again. The address wraps at the top of the space. Releasing select at any bit aborts the transfer cleanly.

Top module: `spi_dbg_slave`

## Requirements
- R1: Each transfer opens with an 8-bit command followed by a 16-bit address. Both are sent MSB first. MOSI is sampled on the rising SCK edge (mode 0), and only while select is low.
- R2: Command 8'h03 is a read. On the falling SCK edge after the last address bit, the slave begins driving the confirmation word {command, address[15:8]} on MISO, MSB first, one bit per falling edge.
- R3: After the confirmation word, a read shifts out the 16-bit contents of the addressed location, MSB first. The memory port fetches a word with a one-cycle `mem_re` pulse, and `mem_rdata` is taken in the cycle after that pulse.
- R4: Command 8'h02 is a write. Sixteen data bits follow the address, MSB first. On the sixteenth bit the slave raises `mem_we` for exactly one clock, with that address and that data.
- R5: While select stays low, a read continues with the words at address+1, address+2 and so on, with no gap and no further confirmation word.
- R6: While select stays low, each further complete 16-bit write word goes to the next address.
- R7: Auto-increment wraps from 16'hFFFF to 16'h0000, for both reads and writes.
- R8: Raising select at any bit ends the transfer. A partly shifted write word is never written. The next select period starts again with a command byte.
- R9: Any command other than 8'h02 or 8'h03 causes no memory access, and MISO stays low until select is released.
- R10: MISO is low while select is high and during the command and address bits.
- R11: After reset, `spi_miso`, `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |

## Verification
The hardest situations to reach from the pins are a select release that lands inside a write word, and an increment that crosses 16'hFFFF during a block. Each one needs a precisely counted run of serial clocks. The stimulus reaches them with a bit-level master task that can stop after any number of bits. Directed transfers start at 16'hFFFF and cut off nine bits into a second word. The memory model logs every write strobe, so an address, a data word or a strobe that should be missing shows up at the memory port. Seeded random transfers then mix reads, writes and unknown commands over block lengths of one to three words.

// File: rtl/spi_dbg_pkg.sv
package spi_dbg_pkg;

  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_ADDR   = 3'd1,
    PH_READ   = 3'd2,
    PH_WRITE  = 3'd3,
    PH_IGNORE = 3'd4
  } phase_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

endpackage

// File: rtl/spi_dbg_sync.sv
module spi_dbg_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_dbg_ctrl.sv
module spi_dbg_ctrl
  import spi_dbg_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sck_rise,
  input  logic              mosi_bit,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_load_val,
  output phase_t            phase,
  output logic              hdr_rd_evt,
  output logic              word_wr_evt
);

  localparam int SR_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int LEN_MAX = (SR_W > CMD_W) ? SR_W : CMD_W;
  localparam int CNT_W = $clog2(LEN_MAX);
  localparam int HI_W  = DATA_W - CMD_W;

  // confirmation word: command byte then upper address bits
  function automatic logic [DATA_W-1:0] confirm_word(input logic [CMD_W-1:0] c,
                                                     input logic [ADDR_W-1:0] a);
    return {c, a[ADDR_W-1 -: HI_W]};
  endfunction

  // block step, wraps at the top of the address space
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic known_op(input logic [CMD_W-1:0] c);
    return (c == CMD_W'(OP_READ)) || (c == CMD_W'(OP_WRITE));
  endfunction

  logic [SR_W-1:0]   in_sr;
  logic [SR_W-1:0]   nxt_sr;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] hold;
  logic              re_q;
  logic              cmd_done, addr_done, word_done;
  logic [ADDR_W-1:0] addr_in;

  assign nxt_sr    = {in_sr[SR_W-2:0], mosi_bit};
  assign addr_in   = nxt_sr[ADDR_W-1:0];
  assign cmd_done  = sck_rise && cs_active && (phase == PH_CMD)  && (cnt == CNT_W'(CMD_W-1));
  assign addr_done = sck_rise && cs_active && (phase == PH_ADDR) && (cnt == CNT_W'(ADDR_W-1));
  assign word_done = sck_rise && cs_active &&
                     ((phase == PH_READ) || (phase == PH_WRITE)) && (cnt == CNT_W'(DATA_W-1));

  assign hdr_rd_evt  = addr_done && (cmd_q == CMD_W'(OP_READ));
  assign word_wr_evt = word_done && (phase == PH_WRITE);

  // read data capture, one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q <= 1'b0;
      hold <= '0;
    end else begin
      re_q <= mem_re;
      if (re_q) hold <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CMD;
      cnt         <= '0;
      in_sr       <= '0;
      cmd_q       <= '0;
      ptr         <= '0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_we      <= 1'b0;
      mem_re      <= 1'b0;
      tx_load     <= 1'b0;
      tx_load_val <= '0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      tx_load <= 1'b0;
      if (!cs_active) begin
        phase <= PH_CMD;
        cnt   <= '0;
        in_sr <= '0;
      end else if (sck_rise) begin
        in_sr <= nxt_sr;
        cnt   <= cnt + CNT_W'(1);
        unique case (phase)
          PH_CMD: begin
            if (cmd_done) begin
              cnt   <= '0;
              cmd_q <= nxt_sr[CMD_W-1:0];
              phase <= known_op(nxt_sr[CMD_W-1:0]) ? PH_ADDR : PH_IGNORE;
            end
          end
          PH_ADDR: begin
            if (addr_done) begin
              cnt <= '0;
              if (cmd_q == CMD_W'(OP_READ)) begin
                phase       <= PH_READ;
                mem_addr    <= addr_in;
                mem_re      <= 1'b1;
                ptr         <= step_addr(addr_in);
                tx_load     <= 1'b1;
                tx_load_val <= confirm_word(cmd_q, addr_in);
              end else begin
                phase <= PH_WRITE;
                ptr   <= addr_in;
              end
            end
          end
          PH_READ: begin
            if (word_done) begin
              cnt         <= '0;
              tx_load     <= 1'b1;
              tx_load_val <= hold;
              mem_addr    <= ptr;
              mem_re      <= 1'b1;
              ptr         <= step_addr(ptr);
            end
          end
          PH_WRITE: begin
            if (word_done) begin
              cnt       <= '0;
              mem_we    <= 1'b1;
              mem_wdata <= nxt_sr[DATA_W-1:0];
              mem_addr  <= ptr;
              ptr       <= step_addr(ptr);
            end
          end
          default: cnt <= cnt;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_dbg_tx.sv
module spi_dbg_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic              miso
);

  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      miso <= 1'b0;
    end else if (clear) begin
      sr   <= '0;
      miso <= 1'b0;
    end else if (load) begin
      sr <= load_val;
    end else if (sck_fall) begin
      miso <= sr[DATA_W-1];
      sr   <= {sr[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_dbg_slave.sv
module spi_dbg_slave
  import spi_dbg_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic             sck_s, sck_prev;
  logic             cs_active, mosi_bit;
  logic             sck_rise, sck_fall;
  logic             tx_load;
  logic [DATA_W-1:0] tx_load_val;
  phase_t           phase;
  logic             hdr_rd_evt, word_wr_evt;

  spi_dbg_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sck, spi_cs_n, spi_mosi}),
    .q    (pins_s)
  );

  assign sck_s     = pins_s[2];
  assign cs_active = ~pins_s[1];
  assign mosi_bit  = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;

  spi_dbg_ctrl #(
    .CMD_W (CMD_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .sck_rise   (sck_rise),
    .mosi_bit   (mosi_bit),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .tx_load    (tx_load),
    .tx_load_val(tx_load_val),
    .phase      (phase),
    .hdr_rd_evt (hdr_rd_evt),
    .word_wr_evt(word_wr_evt)
  );

  spi_dbg_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (~cs_active),
    .sck_fall(sck_fall),
    .load    (tx_load),
    .load_val(tx_load_val),
    .miso    (spi_miso)
  );

endmodule

// File: rtl/spi_dbg_chk.sv
module spi_dbg_chk
  import spi_dbg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_active,
  input phase_t phase,
  input logic   hdr_rd_evt,
  input logic   word_wr_evt,
  input logic   mem_we,
  input logic   mem_re,
  input logic   miso
);

  // R4: a write strobe lasts one clock
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R4: a completed write word produces a strobe next cycle
  a_r4_word_commits: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr_evt |=> mem_we);

  // R2: the end of a read header fetches the first word
  a_r2_fetch_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_rd_evt |=> mem_re);

  // R9: an unknown command touches nothing
  a_r9_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> (!mem_we && !mem_re && !miso));

  // R10: MISO is low once select is released
  a_r10_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !miso);

  // R8: no write strobe follows a released select
  a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !mem_we);

  // R3: strobes never overlap
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

bind spi_dbg_slave spi_dbg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_active  (cs_active),
  .phase      (phase),
  .hdr_rd_evt (hdr_rd_evt),
  .word_wr_evt(word_wr_evt),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .miso       (spi_miso)
);

// File: tb/spi_dbg_slave_tb.sv
module spi_dbg_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int LOG_N      = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dbg_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] seed_word(input int i);
    return 16'((i * 16'h3B1D) ^ 16'hC3A5);
  endfunction

  // memory model, indexed by the low address byte
  logic [15:0] mem [256];
  logic [15:0] wlog_addr [LOG_N];
  logic [15:0] wlog_data [LOG_N];
  int we_cnt = 0;
  int re_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed_word(i);
      mem_rdata <= '0;
    end else begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        if (we_cnt < LOG_N) begin
          wlog_addr[we_cnt] <= mem_addr;
          wlog_data[we_cnt] <= mem_wdata;
        end
        we_cnt <= we_cnt + 1;
      end
      if (mem_re) begin
        mem_rdata <= mem[mem_addr[7:0]];
        re_cnt    <= re_cnt + 1;
      end
    end
  end

  logic [15:0] exp_mem [256];
  logic [15:0] rd_buf [8];
  logic [15:0] wr_buf [8];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic m);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    m = spi_miso;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic sel_on();
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] c, input logic [15:0] a, input int abits, output logic dirty);
    logic m;
    dirty = 1'b0;
    for (int i = 7; i >= 0; i--) begin spi_bit(c[i], m); dirty |= m; end
    for (int i = 15; i >= 16 - abits; i--) begin spi_bit(a[i], m); dirty |= m; end
  endtask

  task automatic do_read(input logic [15:0] a, input int nw, output logic [15:0] conf, output logic dirty);
    logic m;
    sel_on();
    send_hdr(8'h03, a, 16, dirty);
    for (int i = 15; i >= 0; i--) begin spi_bit(1'b0, m); conf[i] = m; end
    for (int w = 0; w < nw; w++)
      for (int i = 15; i >= 0; i--) begin spi_bit(1'b0, m); rd_buf[w][i] = m; end
    sel_off();
  endtask

  task automatic do_write(input logic [15:0] a, input int nw, input int extra);
    logic m, dirty;
    sel_on();
    send_hdr(8'h02, a, 16, dirty);
    for (int w = 0; w < nw; w++)
      for (int i = 15; i >= 0; i--) spi_bit(wr_buf[w][i], m);
    for (int i = 15; i >= 16 - extra; i--) spi_bit(wr_buf[nw][i], m);
    sel_off();
    for (int w = 0; w < nw; w++) exp_mem[8'(a + 16'(w))] = wr_buf[w];
  endtask

  task automatic check_read(input string req, input logic [15:0] a, input int nw);
    logic [15:0] conf;
    logic dirty;
    do_read(a, nw, conf, dirty);
    check(dirty == 1'b0, "R10 miso low in header", 32'(dirty), 32'd0);
    check(conf == {8'h03, a[15:8]}, "R2 confirmation word", 32'(conf), 32'({8'h03, a[15:8]}));
    for (int w = 0; w < nw; w++)
      check(rd_buf[w] == exp_mem[8'(a + 16'(w))], req, 32'(rd_buf[w]), 32'(exp_mem[8'(a + 16'(w))]));
  endtask

  task automatic check_write(input string req, input logic [15:0] a, input int nw);
    int base;
    base = we_cnt;
    do_write(a, nw, 0);
    check(we_cnt == base + nw, "R4 write strobe count", 32'(we_cnt - base), 32'(nw));
    for (int w = 0; w < nw && base + w < LOG_N; w++) begin
      check(wlog_addr[base+w] == 16'(a + 16'(w)), req, 32'(wlog_addr[base+w]), 32'(16'(a + 16'(w))));
      check(wlog_data[base+w] == wr_buf[w], "R4 write data", 32'(wlog_data[base+w]), 32'(wr_buf[w]));
    end
  endtask

  task automatic check_unknown(input logic [7:0] c);
    int w0, r0;
    logic dirty, m, any;
    w0 = we_cnt; r0 = re_cnt; any = 1'b0;
    sel_on();
    send_hdr(c, 16'h1234, 16, dirty);
    for (int i = 0; i < 32; i++) begin spi_bit(1'b1, m); any |= m; end
    sel_off();
    check(!(dirty | any), "R9 miso low on unknown command", 32'(dirty | any), 32'd0);
    check(we_cnt == w0 && re_cnt == r0, "R9 no access on unknown command",
          32'((we_cnt - w0) + (re_cnt - r0)), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = seed_word(i);
    void'($urandom(32'd20240917));
    repeat (5) @(negedge clk);
    // R11: reset state
    check(spi_miso == 1'b0, "R11 miso after reset", 32'(spi_miso), 32'd0);
    check(mem_we == 1'b0, "R11 we after reset", 32'(mem_we), 32'd0);
    check(mem_re == 1'b0, "R11 re after reset", 32'(mem_re), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R3: single read decodes the full address
    check_read("R1 R3 single read", 16'h1234, 1);
    // R4: single write then read back
    wr_buf[0] = 16'hBEEF;
    check_write("R4 write address", 16'h0040, 1);
    check_read("R3 read back", 16'h0040, 1);
    // R6: block write
    wr_buf[0] = 16'h1111; wr_buf[1] = 16'h2222; wr_buf[2] = 16'h3333;
    check_write("R6 block write address", 16'h0100, 3);
    // R5: block read across written words
    check_read("R5 block read", 16'h00FF, 4);
    // R7: wrap on write and read
    wr_buf[0] = 16'hA5A5; wr_buf[1] = 16'h5A5A;
    check_write("R7 write wrap", 16'hFFFF, 2);
    check_read("R7 read wrap", 16'hFFFF, 2);

    // R8: abort inside the second write word
    begin
      int base;
      base = we_cnt;
      wr_buf[0] = 16'h7E57; wr_buf[1] = 16'hDEAD;
      do_write(16'h0050, 1, 9);
      check(we_cnt == base + 1, "R8 partial word not written", 32'(we_cnt - base), 32'd1);
      check_read("R8 location after abort", 16'h0050, 2);
    end
    // R8: abort inside the address, then a clean transfer
    begin
      logic dirty;
      int r0;
      r0 = re_cnt;
      sel_on();
      send_hdr(8'h03, 16'h00F0, 5, dirty);
      sel_off();
      check(re_cnt == r0, "R8 no fetch after address abort", 32'(re_cnt - r0), 32'd0);
      check_read("R8 R1 read after abort", 16'h0077, 1);
    end
    // R9: unknown commands
    check_unknown(8'hA5);
    check_unknown(8'h01);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int op, nw;
      logic [15:0] a;
      op = int'($urandom % 3);
      nw = 1 + int'($urandom % 3);
      a  = 16'($urandom);
      if (t % 8 == 0) a = 16'hFFFE;
      if (op == 0) check_read("R5 random read", a, nw);
      else if (op == 1) begin
        for (int w = 0; w < nw; w++) wr_buf[w] = 16'($urandom);
        check_write("R6 random write", a, nw);
      end else begin
        logic [7:0] c;
        c = 8'($urandom);
        if (c == 8'h02 || c == 8'h03) c ^= 8'h80;
        check_unknown(c);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule